// File: doc/BRIEF.md
# Nibble-Regrouping ARX Key Schedule

This block expands a 64-bit master key into round keys for a five-round add-rotate-xor block cipher. Each round provides five 16-bit subkeys at once. They are derived combinationally from a 64-bit key register. The register's sixteen nibbles are dealt into four interleaved 16-bit groups. Each group passes through its own fixed bit permutation. The four permuted words are then combined with modular addition and XOR.

A load strobe captures a fresh master key and starts round 0. An advance strobe replaces the key register with the concatenation of four of the current subkeys and moves to the next round. Advancing past the last round leaves the key and round index where they are and drops the valid flag. The cipher datapath that consumes the subkeys sits outside this block.

Top module: `arx_subkey_expander`

## Requirements
- R1: The key register is read as nibbles N0..N15, where N0 = key[3:0] and Nn = key[4n+3:4n]. Four groups are formed, each listing its most significant nibble first: G1 = {N0,N4,N8,N12}, G2 = {N2,N6,N10,N14}, G3 = {N1,N5,N9,N13}, G4 = {N3,N7,N11,N15}.
- R2: Each group passes through its own fixed 16-bit permutation. P1 is the full bit reversal of G1. P2 is G2 with its two bytes exchanged. P3 is G3 with bits 2i and 2i+1 exchanged, for every i. P4 is G4 with the bit order reversed inside each nibble.
- R3: sk1 = P1 + P2 + P3 and sk4 = P1 + P4, both taken modulo 2^16, so carries out of bit 15 are dropped.
- R4: sk2 = P3 XOR P2 and sk3 = P1 XOR P3.
- R5: sk5 = sk1 XOR sk2 XOR sk3 XOR sk4.
- R6: When load is high at a clock edge, the key register takes the master key, the round index becomes 0 and valid goes high. From the next cycle, all five subkeys are those of the master key.
- R7: Advance at an edge where valid is high, load is low and the round is below 4 does two things. The key register becomes {sk1,sk2,sk3,sk4}, with sk1 in bits 63:48. The round index increases by one.
- R8: Advance at an edge where the round is 4 and valid is high clears valid. The round index, the key register and the subkeys keep their values.
- R9: While valid is low, advance has no effect. The subkeys, the round index and valid all hold.
- R10: When load and advance are both high at one edge, load takes effect and advance is ignored.
- R11: During reset, valid is 0, the round index is 0 and the key register is zero, so every subkey reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| key_i | input | 64 | Master key, captured on load |
| load_i | input | 1 | Start a new schedule from key_i |
| advance_i | input | 1 | Step to the next round |
| sk1_o | output | 16 | Subkey for stage 1 of the current round |
| sk2_o | output | 16 | Subkey for stage 2 |
| sk3_o | output | 16 | Subkey for stage 3 |
| sk4_o | output | 16 | Subkey for stage 4 |
| sk5_o | output | 16 | Subkey for stage 5 |
| round_o | output | 3 | Current round index, 0 to 4 |
| valid_o | output | 1 | Subkeys belong to a live schedule |

## Verification
Loading a key and stepping the round can be requested in the same cycle. The bench raises both strobes together in the middle of a schedule and right after the last round. It expects the round index to return to 0 and the subkeys to be those of the new key, with no trace of the feedback step. The random phase raises load and advance with independent probabilities, so this collision also arises at arbitrary rounds. A bench model checks every cycle, and the model applies load before advance.

// File: rtl/arx_ks_pkg.sv
package arx_ks_pkg;
   // Permutation applied to one 16-bit group; order matches group index.
   typedef enum logic [1:0] {
      PERM_REVERSE    = 2'd0,
      PERM_HALF_SWAP  = 2'd1,
      PERM_PAIR_SWAP  = 2'd2,
      PERM_NIBBLE_REV = 2'd3
   } perm_mode_e;

   localparam int NUM_GROUPS = 4;
   localparam int NIB_W      = 4;

   // First key nibble feeding each group (the group then steps by 4 nibbles).
   function automatic int group_base(input int g);
      case (g)
         0:       return 0;
         1:       return 2;
         2:       return 1;
         default: return 3;
      endcase
   endfunction
endpackage

// File: rtl/ks_nibble_regroup.sv
module ks_nibble_regroup
   import arx_ks_pkg::*;
#(
   parameter int SUB_W = 16
) (
   input  logic [NUM_GROUPS*SUB_W-1:0]        key_i,
   output logic [NUM_GROUPS-1:0][SUB_W-1:0]   grp_o
);
   localparam int NIBS_PER_GRP = SUB_W / NIB_W;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      localparam int BASE = group_base(g);
      for (genvar j = 0; j < NIBS_PER_GRP; j++) begin : g_nib
         // first-listed nibble lands in the most significant slot
         assign grp_o[g][SUB_W-1-NIB_W*j -: NIB_W] =
            key_i[NIB_W*(BASE + NUM_GROUPS*j) +: NIB_W];
      end
   end
endmodule

// File: rtl/ks_bit_permute.sv
module ks_bit_permute
   import arx_ks_pkg::*;
#(
   parameter int         SUB_W = 16,
   parameter perm_mode_e MODE  = PERM_REVERSE
) (
   input  logic [SUB_W-1:0] din_i,
   output logic [SUB_W-1:0] dout_o
);
   localparam int HALF = SUB_W / 2;

   if (MODE == PERM_REVERSE) begin : g_rev
      for (genvar i = 0; i < SUB_W; i++) begin : g_bit
         assign dout_o[i] = din_i[SUB_W-1-i];
      end
   end else if (MODE == PERM_HALF_SWAP) begin : g_half
      assign dout_o = {din_i[HALF-1:0], din_i[SUB_W-1:HALF]};
   end else if (MODE == PERM_PAIR_SWAP) begin : g_pair
      for (genvar i = 0; i < SUB_W; i++) begin : g_bit
         assign dout_o[i] = din_i[i ^ 1];
      end
   end else begin : g_nrev
      for (genvar n = 0; n < SUB_W / NIB_W; n++) begin : g_nib
         for (genvar b = 0; b < NIB_W; b++) begin : g_bit
            assign dout_o[NIB_W*n + b] = din_i[NIB_W*n + NIB_W-1-b];
         end
      end
   end
endmodule

// File: rtl/ks_subkey_combine.sv
module ks_subkey_combine
   import arx_ks_pkg::*;
#(
   parameter int SUB_W = 16
) (
   input  logic [NUM_GROUPS-1:0][SUB_W-1:0] perm_i,
   output logic [4:0][SUB_W-1:0]            sk_o
);
   logic [SUB_W-1:0] add3, add2, x23, x13;

   always_comb begin
      add3 = perm_i[0] + perm_i[1] + perm_i[2];
      add2 = perm_i[0] + perm_i[3];
      x23  = perm_i[2] ^ perm_i[1];
      x13  = perm_i[0] ^ perm_i[2];
      sk_o[0] = add3;
      sk_o[1] = x23;
      sk_o[2] = x13;
      sk_o[3] = add2;
      sk_o[4] = add3 ^ x23 ^ x13 ^ add2;
   end
endmodule

// File: rtl/arx_subkey_expander.sv
module arx_subkey_expander
   import arx_ks_pkg::*;
#(
   parameter int SUB_W      = 16,
   parameter int NUM_ROUNDS = 5,
   parameter int KEY_W      = NUM_GROUPS * SUB_W,
   parameter int RND_W      = $clog2(NUM_ROUNDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [KEY_W-1:0] key_i,
   input  logic             load_i,
   input  logic             advance_i,
   output logic [SUB_W-1:0] sk1_o,
   output logic [SUB_W-1:0] sk2_o,
   output logic [SUB_W-1:0] sk3_o,
   output logic [SUB_W-1:0] sk4_o,
   output logic [SUB_W-1:0] sk5_o,
   output logic [RND_W-1:0] round_o,
   output logic             valid_o
);
   localparam int LAST_RND = NUM_ROUNDS - 1;

   // elaboration-time parameter checks
   if (SUB_W % (2*NIB_W) != 0 || SUB_W < 8) begin : g_bad_sub_w
      $error("SUB_W must be a multiple of 8 and at least 8");
   end
   if (KEY_W != NUM_GROUPS * SUB_W) begin : g_bad_key_w
      $error("KEY_W must equal four subkeys");
   end
   if (NUM_ROUNDS < 2 || (1 << RND_W) < NUM_ROUNDS) begin : g_bad_rounds
      $error("NUM_ROUNDS must be at least 2 and fit in RND_W bits");
   end

   logic [KEY_W-1:0]                 key_q;
   logic [RND_W-1:0]                 rnd_q;
   logic                             vld_q;
   logic [NUM_GROUPS-1:0][SUB_W-1:0] grp;
   logic [NUM_GROUPS-1:0][SUB_W-1:0] perm;
   logic [4:0][SUB_W-1:0]            sk;
   logic [KEY_W-1:0]                 key_next;
   logic                             at_last;

   ks_nibble_regroup #(.SUB_W(SUB_W)) u_regroup (
      .key_i (key_q),
      .grp_o (grp)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_perm
      ks_bit_permute #(.SUB_W(SUB_W), .MODE(perm_mode_e'(g))) u_perm (
         .din_i  (grp[g]),
         .dout_o (perm[g])
      );
   end

   ks_subkey_combine #(.SUB_W(SUB_W)) u_combine (
      .perm_i (perm),
      .sk_o   (sk)
   );

   assign key_next = {sk[0], sk[1], sk[2], sk[3]};
   assign at_last  = (rnd_q == RND_W'(LAST_RND));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         key_q <= '0;
         rnd_q <= '0;
         vld_q <= 1'b0;
      end else if (load_i) begin
         key_q <= key_i;
         rnd_q <= '0;
         vld_q <= 1'b1;
      end else if (advance_i && vld_q) begin
         if (at_last) begin
            vld_q <= 1'b0;
         end else begin
            key_q <= key_next;
            rnd_q <= rnd_q + RND_W'(1);
         end
      end
   end

   assign sk1_o   = sk[0];
   assign sk2_o   = sk[1];
   assign sk3_o   = sk[2];
   assign sk4_o   = sk[3];
   assign sk5_o   = sk[4];
   assign round_o = rnd_q;
   assign valid_o = vld_q;

   assert_load_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (valid_o && round_o == '0 && key_q == $past(key_i)));

   assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && advance_i && valid_o) |=> (round_o == '0 && key_q == $past(key_i)));

   assert_round_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && advance_i && valid_o && round_o != RND_W'(LAST_RND))
      |=> (valid_o && round_o == $past(round_o) + RND_W'(1)));

   assert_key_feedback_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && advance_i && valid_o && round_o != RND_W'(LAST_RND))
      |=> (key_q == {$past(sk1_o), $past(sk2_o), $past(sk3_o), $past(sk4_o)}));

   assert_end_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && advance_i && valid_o && round_o == RND_W'(LAST_RND))
      |=> (!valid_o && $stable(round_o) && $stable(sk5_o) && $stable(sk1_o)));

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !valid_o) |=> (!valid_o && $stable(round_o) && $stable(key_q)));

   assert_round_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (round_o <= RND_W'(LAST_RND)));
endmodule

// File: tb/arx_subkey_expander_tb.sv
module arx_subkey_expander_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] key_in = '0;
   logic        load = 1'b0;
   logic        advance = 1'b0;
   logic [15:0] sk1, sk2, sk3, sk4, sk5;
   logic [2:0]  round;
   logic        valid;

   int n_checks = 0;
   int n_bad    = 0;

   // reference state
   logic [63:0] m_key = '0;
   int          m_rnd = 0;
   bit          m_vld = 0;

   always #5 clk = ~clk;

   arx_subkey_expander dut_i (
      .clk(clk), .rst_n(rst_n), .key_i(key_in), .load_i(load), .advance_i(advance),
      .sk1_o(sk1), .sk2_o(sk2), .sk3_o(sk3), .sk4_o(sk4), .sk5_o(sk5),
      .round_o(round), .valid_o(valid)
   );

   function automatic logic [15:0] rev16(input logic [15:0] c);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) r[15-i] = c[i];
      return r;
   endfunction

   function automatic logic [15:0] pairx(input logic [15:0] c);
      logic [15:0] r;
      for (int i = 0; i < 8; i++) begin
         r[2*i]   = c[2*i+1];
         r[2*i+1] = c[2*i];
      end
      return r;
   endfunction

   function automatic logic [15:0] nibrev(input logic [15:0] c);
      logic [15:0] r;
      for (int n = 0; n < 4; n++)
         for (int b = 0; b < 4; b++) r[4*n+3-b] = c[4*n+b];
      return r;
   endfunction

   // returns {k1,k2,k3,k4,k5}
   function automatic logic [79:0] expect_keys(input logic [63:0] k);
      logic [15:0] c1, c2, c3, c4, b1, b2, b3, b4, k1, k2, k3, k4;
      c1 = {k[3:0],   k[19:16], k[35:32], k[51:48]};
      c2 = {k[11:8],  k[27:24], k[43:40], k[59:56]};
      c3 = {k[7:4],   k[23:20], k[39:36], k[55:52]};
      c4 = {k[15:12], k[31:28], k[47:44], k[63:60]};
      b1 = rev16(c1);
      b2 = {c2[7:0], c2[15:8]};
      b3 = pairx(c3);
      b4 = nibrev(c4);
      k1 = 16'((32'(b1) + 32'(b2) + 32'(b3)) % 32'h10000);
      k2 = b2 ^ b3;
      k3 = b3 ^ b1;
      k4 = 16'((32'(b4) + 32'(b1)) % 32'h10000);
      return {k1, k2, k3, k4, k1 ^ k2 ^ k3 ^ k4};
   endfunction

   task automatic chk(input string req, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      logic [79:0] e;
      e = expect_keys(m_key);
      chk(req, "round", 64'(round), 64'(m_rnd));
      chk(req, "valid", 64'(valid), 64'(m_vld));
      chk("R3", "sk1", 64'(sk1), 64'(e[79:64]));
      chk("R4", "sk2", 64'(sk2), 64'(e[63:48]));
      chk("R4", "sk3", 64'(sk3), 64'(e[47:32]));
      chk("R3", "sk4", 64'(sk4), 64'(e[31:16]));
      chk("R5", "sk5", 64'(sk5), 64'(e[15:0]));
   endtask

   // one clock with given strobes; model updated, outputs checked at the next falling edge
   task automatic step(input bit l, input bit a, input logic [63:0] k, input string req);
      logic [79:0] e;
      @(negedge clk);
      load = l; advance = a; key_in = k;
      e = expect_keys(m_key);
      @(negedge clk);
      load = 1'b0; advance = 1'b0;
      if (l) begin
         m_key = k; m_rnd = 0; m_vld = 1;
      end else if (a && m_vld) begin
         if (m_rnd == 4) m_vld = 0;
         else begin
            m_key = e[79:16];
            m_rnd++;
         end
      end
      check_all(req);
   endtask

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      // R11: reset state
      repeat (3) @(negedge clk);
      check_all("R11");
      rst_n = 1'b1;
      // R9: advance with no live schedule
      step(0, 1, 64'hDEAD_BEEF_0000_1111, "R9");
      step(0, 0, '0, "R9");
      // R1/R2: one-hot nibbles show group placement and permutation
      for (int n = 0; n < 16; n++) step(1, 0, 64'h1 << (4*n), "R1");
      for (int b = 0; b < 64; b += 5) step(1, 0, 64'h1 << b, "R2");
      // R6/R7/R8: full schedule then overrun
      step(1, 0, 64'h0123_4567_89AB_CDEF, "R6");
      for (int r = 0; r < 4; r++) step(0, 1, '0, "R7");
      step(0, 1, '0, "R8");
      step(0, 1, '0, "R8");
      step(0, 0, '0, "R9");
      // R3: carries dropped
      step(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
      step(0, 1, '0, "R3");
      // R10: load and advance together, mid-schedule and after the end
      step(1, 0, 64'h1357_9BDF_2468_ACE0, "R6");
      step(0, 1, '0, "R7");
      step(0, 1, '0, "R7");
      step(1, 1, 64'hA5A5_0F0F_3C3C_9999, "R10");
      for (int r = 0; r < 5; r++) step(0, 1, '0, "R8");
      step(1, 1, 64'h0F1E_2D3C_4B5A_6978, "R10");
      // random phase
      for (int t = 0; t < 60; t++) begin
         step(1, 0, {$urandom, $urandom}, "R6");
         for (int s = 0; s < 10; s++) begin
            bit l, a;
            l = ($urandom % 8) == 0;
            a = ($urandom % 4) != 0;
            step(l, a, {$urandom, $urandom}, (l && a) ? "R10" : "R7");
         end
      end
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end
endmodule